// File: doc/BRIEF.md
# Dual-Read Register File with Byte-Extending Write

This block is the general register storage of a small 16-bit processor. It holds fourteen 16-bit registers at indices 0 to 13. There is one write port and two read ports, A and B, that work independently, and each port is addressed by a 4-bit index. Every strobe is active-low. Index 0 is a hard zero register. Indices 14 and 15 belong to registers that live outside this block, so they select no storage here.

Write data first passes through an extension stage. That stage can pass the whole word through. It can also keep only the low byte and fill the upper byte with zeros, or with copies of bit 7. A synchronous active-low reset clears every register on a single clock edge. It does this by forcing all write enables on while it puts zero on the write path. The read ports model a tri-state bus as a data value plus a drive flag. An undriven port shows zero on its data output.

Top module: `regbank16`

## Requirements
- R1: While `wr_n` is low and `rst_n` is high, the register selected by `wr_idx` (indices 1 to 13) takes the extended write value at the next rising clock edge. While `wr_n` is high, no register changes.
- R2: While `rda_n` is low and `rda_idx` is between 0 and 13, `qa_drv` is 1 and `qa` shows that register. While `rda_n` is high, `qa_drv` is 0 and `qa` is zero.
- R3: Port B behaves like port A, using `rdb_n`, `rdb_idx`, `qb` and `qb_drv`. Its strobe and index are independent of port A.
- R4: When `byte_n` is high, all 16 bits of `din` are written unchanged. When `byte_n` is low and `unsgn_n` is low, bits 7:0 of `din` are written and bits 15:8 are zero.
- R5: When `byte_n` is low and `unsgn_n` is high, bits 7:0 of `din` are written and each of bits 15:8 equals `din[7]`.
- R6: A rising edge with `rst_n` low sets all fourteen registers to zero. This holds whatever the values of `wr_n`, `wr_idx`, `din`, `byte_n` and `unsgn_n`.
- R7: Index 0 always reads as zero with the drive flag set, even after a write to index 0.
- R8: A write to index 14 or 15 changes no register. A read of index 14 or 15 leaves that port's drive flag at 0 and its data at zero.
- R9: A read of a register in the same cycle as a write to it returns the value held before the clock edge. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising-edge active |
| rst_n | input | 1 | Synchronous reset, active-low; clears all registers |
| wr_n | input | 1 | Write strobe, active-low |
| wr_idx | input | 4 | Write register index |
| din | input | 16 | Write data before extension |
| byte_n | input | 1 | Byte-load select, active-low |
| unsgn_n | input | 1 | Unsigned (zero-fill) select, active-low; used only in byte mode |
| rda_n | input | 1 | Read port A strobe, active-low |
| rda_idx | input | 4 | Read port A index |
| rdb_n | input | 1 | Read port B strobe, active-low |
| rdb_idx | input | 4 | Read port B index |
| qa | output | 16 | Port A data; zero when not driven |
| qa_drv | output | 1 | Port A drive flag |
| qb | output | 16 | Port B data; zero when not driven |
| qb_drv | output | 1 | Port B drive flag |

## Verification
The bench writes byte loads whose bit 7 is set and others whose bit 7 is clear. A stage that swapped the fill polarity, or took the fill bit from the wrong position, would leave the wrong upper byte. It writes to index 0 and to indices 14 and 15, and then reads every register back. A design that stored into the zero register, or aliased the out-of-range indices onto real storage, would show a changed value. It asserts reset together with an active full write and byte-select settings. Logic that let the write strobe or the extension beat reset would leave a nonzero register. It also samples a read before and after a write edge to the same register. A bypass path, or a write that landed early, would show the new value one cycle too soon.

// File: rtl/regbank_pkg.sv
// Package regbank_pkg
// Shared sizing defaults and the write-path fill mode for the register bank.
// Assumes the byte width divides the word and that the register count fits
// in the index width.
package regbank_pkg;
    localparam int DATA_W_DEF   = 16;
    localparam int BYTE_W_DEF   = 8;
    localparam int IDX_W_DEF    = 4;
    localparam int NUM_REGS_DEF = 14;

    // How the upper part of a written word is formed.
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,   // full word passes through
        FILL_ZERO = 2'd1,   // upper byte cleared
        FILL_SIGN = 2'd2    // upper byte copies the low-byte sign bit
    } fill_mode_t;
endpackage

// File: rtl/regbank_extend.sv
// Module regbank_extend
// Forms the internal write-path value from raw input data. In byte mode the
// low byte is kept and the upper bits are zero- or sign-filled. While reset
// is low the path is forced to zero, whatever the selects are.
// Assumes DATA_W > BYTE_W.
module regbank_extend
    import regbank_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              byte_n,
    input  logic              unsgn_n,
    output logic [DATA_W-1:0] wpath
);
    localparam int UP_W = DATA_W - BYTE_W;

    fill_mode_t        mode;
    logic [DATA_W-1:0] ext;

    // Choose the fill mode from the two active-low selects.
    always_comb begin
        if (byte_n)
            mode = FILL_NONE;
        else if (!unsgn_n)
            mode = FILL_ZERO;
        else
            mode = FILL_SIGN;
    end

    // Build the extended word for the selected mode.
    always_comb begin
        case (mode)
            FILL_ZERO: ext = {{UP_W{1'b0}}, din[BYTE_W-1:0]};
            FILL_SIGN: ext = {{UP_W{din[BYTE_W-1]}}, din[BYTE_W-1:0]};
            default:   ext = din;
        endcase
    end

    // Reset owns the write path: it drives zero in place of the extended word.
    always_comb begin
        wpath = rst_n ? ext : '0;
    end
endmodule

// File: rtl/regbank_decode.sv
// Module regbank_decode
// Turns the write strobe and index into one enable per stored register.
// Reset forces every enable on. Index 0 has no storage, so no enable is
// produced for it, and indices at or above NUM_REGS select nothing.
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int IDX_W    = IDX_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic                  rst_n,
    input  logic                  wr_n,
    input  logic [IDX_W-1:0]      wr_idx,
    output logic [NUM_REGS-1:1]   we
);
    genvar gi;
    generate
        for (gi = 1; gi < NUM_REGS; gi++) begin : g_dec
            // One enable: forced by reset, else strobe and index match.
            always_comb begin
                we[gi] = !rst_n || (!wr_n && (wr_idx == IDX_W'(gi)));
            end
        end
    endgenerate
endmodule

// File: rtl/regbank_store.sv
// Module regbank_store
// Holds the registers. Entry 0 is a constant zero; every other entry
// captures the write path on a rising edge when its enable is set. Reset
// reaches the storage only through the forced enables and the zero path.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic                              clk,
    input  logic [NUM_REGS-1:1]               we,
    input  logic [DATA_W-1:0]                 wpath,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   q
);
    // Entry 0 is hard-wired to zero.
    assign q[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < NUM_REGS; gi++) begin : g_reg
            // Capture the write path when this entry is enabled.
            always_ff @(posedge clk) begin
                if (we[gi])
                    q[gi] <= wpath;
            end
        end
    endgenerate
endmodule

// File: rtl/regbank_readport.sv
// Module regbank_readport
// One read port. It selects a register by index and drives it while the
// active-low strobe is low and the index names real storage. When not
// driven, the data output is zero and the drive flag is clear.
module regbank_readport
    import regbank_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic                              rd_n,
    input  logic [IDX_W-1:0]                  rd_idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   q,
    output logic [DATA_W-1:0]                 data,
    output logic                              drv
);
    logic [DATA_W-1:0] sel;
    logic              hit;

    // Search the register array for the indexed entry.
    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                sel = q[i];
                hit = 1'b1;
            end
        end
    end

    // Gate the selection with the strobe to form the bus model.
    always_comb begin
        drv  = !rd_n && hit;
        data = drv ? sel : '0;
    end
endmodule

// File: rtl/regbank16.sv
// Module regbank16
// Register bank top: one extending write port and two independent read
// ports over fourteen registers. Reads are combinational and show the value
// held before the next edge. Reset is synchronous and active-low.
module regbank16
    import regbank_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int BYTE_W   = BYTE_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] din,
    input  logic              byte_n,
    input  logic              unsgn_n,
    input  logic              rda_n,
    input  logic [IDX_W-1:0]  rda_idx,
    input  logic              rdb_n,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [DATA_W-1:0] qa,
    output logic              qa_drv,
    output logic [DATA_W-1:0] qb,
    output logic              qb_drv
);
    logic [DATA_W-1:0]               wpath;
    logic [NUM_REGS-1:1]             we;
    logic [NUM_REGS-1:0][DATA_W-1:0] q;

    regbank_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
        .rst_n   (rst_n),
        .din     (din),
        .byte_n  (byte_n),
        .unsgn_n (unsgn_n),
        .wpath   (wpath)
    );

    regbank_decode #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_dec (
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .wr_idx (wr_idx),
        .we     (we)
    );

    regbank_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk   (clk),
        .we    (we),
        .wpath (wpath),
        .q     (q)
    );

    regbank_readport #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_rda (
        .rd_n   (rda_n),
        .rd_idx (rda_idx),
        .q      (q),
        .data   (qa),
        .drv    (qa_drv)
    );

    regbank_readport #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_rdb (
        .rd_n   (rdb_n),
        .rd_idx (rdb_idx),
        .q      (q),
        .data   (qb),
        .drv    (qb_drv)
    );
endmodule

// File: rtl/regbank16_chk.sv
// Module regbank16_chk
// Property checker for regbank16, bound to every instance. It watches only
// the ports and keeps its own view of the extended write value.
module regbank16_chk
    import regbank_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int BYTE_W   = BYTE_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] din,
    input logic              byte_n,
    input logic              unsgn_n,
    input logic              rda_n,
    input logic [IDX_W-1:0]  rda_idx,
    input logic              rdb_n,
    input logic [IDX_W-1:0]  rdb_idx,
    input logic [DATA_W-1:0] qa,
    input logic              qa_drv,
    input logic [DATA_W-1:0] qb,
    input logic              qb_drv
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [DATA_W-1:0] want;

    // Expected stored value for the inputs of this cycle.
    always_comb begin
        if (byte_n)
            want = din;
        else
            want = {{(DATA_W-BYTE_W){din[BYTE_W-1] & unsgn_n}}, din[BYTE_W-1:0]};
    end

    assert_undriven_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !qa_drv |-> (qa == '0));

    assert_undriven_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !qb_drv |-> (qb == '0));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rda_n && rda_idx == '0) |-> (qa_drv && qa == '0));

    assert_high_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdb_n && rdb_idx > LAST_IDX) |-> !qb_drv);

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !rda_n) |-> (qa == '0));

    // R1, R4, R5: a write is visible on port A in the following cycle.
    assert_write_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_n) && $past(wr_idx) != '0 &&
         $past(wr_idx) <= LAST_IDX && !rda_n && rda_idx == $past(wr_idx))
        |-> (qa == $past(want)));
endmodule

bind regbank16 regbank16_chk #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_idx(wr_idx), .din(din),
    .byte_n(byte_n), .unsgn_n(unsgn_n), .rda_n(rda_n), .rda_idx(rda_idx),
    .rdb_n(rdb_n), .rdb_idx(rdb_idx), .qa(qa), .qa_drv(qa_drv),
    .qb(qb), .qb_drv(qb_drv)
);

// File: tb/sim_regbank16.sv
// Directed bench for regbank16. Inputs change on falling edges; outputs are
// sampled 1 ns later, well before the next rising edge.
`timescale 1ns/1ps
module sim_regbank16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  wr_idx = '0;
    logic [15:0] din = '0;
    logic        byte_n = 1'b1;
    logic        unsgn_n = 1'b1;
    logic        rda_n = 1'b1;
    logic [3:0]  rda_idx = '0;
    logic        rdb_n = 1'b1;
    logic [3:0]  rdb_idx = '0;
    logic [15:0] qa, qb;
    logic        qa_drv, qb_drv;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [14];

    always #2.5 clk = ~clk;

    regbank16 u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_idx(wr_idx), .din(din),
        .byte_n(byte_n), .unsgn_n(unsgn_n), .rda_n(rda_n), .rda_idx(rda_idx),
        .rdb_n(rdb_n), .rdb_idx(rdb_idx), .qa(qa), .qa_drv(qa_drv),
        .qb(qb), .qb_drv(qb_drv)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one write across one rising edge; model holds the expectation.
    task automatic do_write(input logic [3:0] idx, input logic [15:0] d,
                            input logic bn, input logic un);
        @(negedge clk);
        wr_n = 1'b0; wr_idx = idx; din = d; byte_n = bn; unsgn_n = un;
        @(negedge clk);
        wr_n = 1'b1; byte_n = 1'b1; unsgn_n = 1'b1;
    endtask

    // Read both ports and compare data and drive flags.
    task automatic rd2(input string tag, input logic [3:0] ai, input logic [3:0] bi,
                       input logic [15:0] ea, input logic [15:0] eb);
        @(negedge clk);
        rda_n = 1'b0; rda_idx = ai; rdb_n = 1'b0; rdb_idx = bi;
        #1;
        chk({tag, " A data"}, qa, ea);
        chk({tag, " B data"}, qb, eb);
        chk({tag, " A drv"}, {15'd0, qa_drv}, {15'd0, ai < 4'd14});
        chk({tag, " B drv"}, {15'd0, qb_drv}, {15'd0, bi < 4'd14});
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 14; i++)
            rd2(tag, 4'(i), 4'(13 - i), model[i], model[13 - i]);
    endtask

    task automatic t_reset;
        // R6: one reset edge clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 14; i++) model[i] = '0;
        check_all("R6 reset");
        // R2: strobe high means no drive and zero data.
        @(negedge clk); rda_n = 1'b1; rdb_n = 1'b1; #1;
        chk("R2 idle A drv", {15'd0, qa_drv}, 16'd0);
        chk("R2 idle A data", qa, 16'd0);
        chk("R3 idle B drv", {15'd0, qb_drv}, 16'd0);
    endtask

    task automatic t_full;
        do_write(4'd3, 16'hBEEF, 1'b1, 1'b1);  model[3] = 16'hBEEF;
        do_write(4'd13, 16'h1234, 1'b1, 1'b0); model[13] = 16'h1234;
        rd2("R1 full write", 4'd3, 4'd13, 16'hBEEF, 16'h1234);
        // R1: strobe high writes nothing.
        @(negedge clk); wr_n = 1'b1; wr_idx = 4'd3; din = 16'h5555;
        @(negedge clk);
        rd2("R1 strobe high", 4'd3, 4'd3, 16'hBEEF, 16'hBEEF);
    endtask

    task automatic t_indep;
        // R3: A off while B on, then the reverse.
        @(negedge clk); rda_n = 1'b1; rdb_n = 1'b0; rdb_idx = 4'd13; #1;
        chk("R3 A off drv", {15'd0, qa_drv}, 16'd0);
        chk("R3 A off data", qa, 16'd0);
        chk("R3 B on data", qb, 16'h1234);
        @(negedge clk); rda_n = 1'b0; rda_idx = 4'd3; rdb_n = 1'b1; #1;
        chk("R2 A on data", qa, 16'hBEEF);
        chk("R3 B off drv", {15'd0, qb_drv}, 16'd0);
    endtask

    task automatic t_byte;
        do_write(4'd4, 16'h12F0, 1'b0, 1'b0); model[4] = 16'h00F0;
        do_write(4'd5, 16'h34F0, 1'b0, 1'b1); model[5] = 16'hFFF0;
        do_write(4'd6, 16'hAB70, 1'b0, 1'b1); model[6] = 16'h0070;
        do_write(4'd7, 16'hCD70, 1'b0, 1'b0); model[7] = 16'h0070;
        rd2("R4 zero fill", 4'd4, 4'd7, 16'h00F0, 16'h0070);
        rd2("R5 sign fill", 4'd5, 4'd6, 16'hFFF0, 16'h0070);
    endtask

    task automatic t_zero_reg;
        do_write(4'd0, 16'hFFFF, 1'b1, 1'b1);
        rd2("R7 zero reg", 4'd0, 4'd0, 16'h0000, 16'h0000);
    endtask

    task automatic t_high_idx;
        do_write(4'd14, 16'hA5A5, 1'b1, 1'b1);
        do_write(4'd15, 16'h5A5A, 1'b1, 1'b1);
        check_all("R8 high write");
        rd2("R8 high read", 4'd14, 4'd15, 16'h0000, 16'h0000);
    endtask

    task automatic t_rdw;
        // R9: old value before the edge, new value after it.
        @(negedge clk);
        wr_n = 1'b0; wr_idx = 4'd3; din = 16'h7777; byte_n = 1'b1;
        rda_n = 1'b0; rda_idx = 4'd3; #1;
        chk("R9 before edge", qa, 16'hBEEF);
        @(negedge clk); wr_n = 1'b1; #1;
        chk("R9 after edge", qa, 16'h7777);
        model[3] = 16'h7777;
    endtask

    task automatic t_reset_prio;
        // R6: reset beats the write strobe and the byte/sign selects.
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b0; wr_idx = 4'd9; din = 16'hFFFF;
        byte_n = 1'b0; unsgn_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; wr_n = 1'b1; byte_n = 1'b1;
        for (int i = 0; i < 14; i++) model[i] = '0;
        check_all("R6 reset priority");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full();
        t_indep();
        t_byte();
        t_zero_reg();
        t_high_idx();
        t_rdw();
        t_reset_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule